// File: doc/BRIEF.md
# CAN controller host register interface

This block is the processor-facing side of a small CAN controller that runs in basic mode. A host reaches it through an 8-bit address/data bus with separate write and read strobes. Through this bus the host configures the controller, fills a transmit frame buffer, issues commands, and reads received frames and status. On the other side, a short handshake connects it to a bit-stream engine, which is not part of this block. The engine is told when a frame waits to be sent. It reports back when it has taken the frame and when the frame has gone out. It also delivers received frames one at a time.

The configuration registers are the acceptance code and mask, two bus-timing bytes, an output-control byte and a clock-divider byte. The host can change them only while the controller is held in reset mode. The controller enters reset mode at power-up, when the host sets the reset-request bit, or by itself when the engine reports an error. Received frames are first checked against the acceptance filter. Frames that pass go into a two-entry queue, and the host reads the oldest one through a fixed window of addresses. Events become interrupt flags only when their enable bits allow it. The flags drive an active-low interrupt pin, and reading the interrupt register clears them.

Top module: `can_hri_top`

Address map (decimal): 0 control, 1 command, 2 status, 3 interrupt, 4 acceptance code, 5 acceptance mask, 6 bus timing 0, 7 bus timing 1, 8 output control, 9 clock divider, 10..19 transmit buffer, 20..29 receive window. In both frame buffers, buffer byte 0 is identifier bits 10..3 and byte 1 is {identifier bits 2..0, RTR, DLC[3:0]} (bits 7..5, bit 4, bits 3..0). Buffer bytes 2..9 are data bytes 0..7.

## Requirements
- R1: After reset the registers read as follows: control 0x01 (reset mode, all enables off), status 0x06, interrupt 0x00 and every configuration register 0x00. irq_n is 1 and tx_req is 0.
- R2: Writes to the configuration registers (addresses 4..9) take effect only while control bit 0 (reset request) is 1. While it is 0 such writes are ignored and the old value reads back.
- R3: Control bits are 0 = reset request, 1 = receive enable, 2 = transmit enable, 3 = error enable and 4 = overrun enable. A control write stores bits 4..0 and reads back with bits 7..5 zero. Writing bit 0 as 0 leaves reset mode.
- R4: Command bits are 0 = transmit request, 1 = abort and 2 = release receive buffer. Each acts for the single write cycle only, and the command address always reads 0x00.
- R5: Status bits are 0 = RBS (receive frame pending), 1 = TBS (transmit buffer released) and 2 = TCS (transmission complete). A transmit request with TBS=1 outside reset mode clears TBS and TCS and raises tx_req. The request is ignored in reset mode. While TBS=0, writes to the transmit buffer are ignored.
- R6: A tx_done pulse after tx_start sets TBS and TCS. It also raises interrupt bit 1 (transmit) if transmit enable is set.
- R7: An abort while tx_req is high drops tx_req and sets TBS with TCS left at 0. An abort after tx_start has no effect.
- R8: tx_id is {byte0, byte1[7:5]}, tx_rtr is byte1[4], tx_dlc is byte1[3:0], and tx_data byte i is buffer byte 2+i.
- R9: A received frame is accepted only outside reset mode and only if its first ID byte equals the acceptance code in every bit where the acceptance mask bit is 0. A 1 in the mask marks a don't-care bit. Rejected frames leave no trace.
- R10: Up to two accepted frames are queued and RBS stays 1 while any is queued. A release frees the oldest frame. A frame accepted while both entries are full is dropped, and it raises interrupt bit 3 (overrun) if overrun enable is set.
- R11: The receive window shows the oldest frame. A data byte whose index is at or beyond the effective length reads 0x00, and a DLC above 8 counts as 8.
- R12: Interrupt bits are 0 = receive, 1 = transmit, 2 = error, 3 = overrun and 4 = wake-up. Each event sets its flag only if its enable bit is set, except wake-up, which has no enable. irq_n is 0 exactly while any flag is set.
- R13: Reading the interrupt register returns the flags and clears them at that clock edge. An event arriving in the same cycle is kept.
- R14: An err_evt pulse sets the reset request bit and keeps the enables. It raises interrupt bit 2 if error enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data for the current address |
| irq_n | output | 1 | Active-low interrupt |
| reset_mode | output | 1 | Controller is held in reset mode |
| bt0 | output | 8 | Bus timing byte 0 toward the engine |
| bt1 | output | 8 | Bus timing byte 1 toward the engine |
| ocr | output | 8 | Output control byte toward the engine |
| cdr | output | 8 | Clock divider byte toward the engine |
| tx_req | output | 1 | A frame waits for the engine |
| tx_start | input | 1 | Engine has taken the frame |
| tx_done | input | 1 | Engine has finished sending |
| tx_id | output | 11 | Transmit identifier |
| tx_rtr | output | 1 | Transmit remote-frame flag |
| tx_dlc | output | 4 | Transmit data length code |
| tx_data | output | 8*DATA_BYTES | Transmit data, byte i at bits 8i+7..8i |
| rx_valid | input | 1 | Received frame strobe |
| rx_id_hi | input | 8 | Received ID byte 0 |
| rx_id_lo | input | 8 | Received ID byte 1 |
| rx_data | input | 8*DATA_BYTES | Received data, byte i at bits 8i+7..8i |
| err_evt | input | 1 | Error event from the engine |
| wake_evt | input | 1 | Wake-up event from the engine |

## Verification
Several rules are checked on every cycle. Configuration timing must not change after a write outside reset mode, and the command address must read as zero. tx_req and TBS must never be high together, tx_done on a started frame must release the buffer, and an error must force reset mode. An interrupt read with no event in the same cycle must clear the pin, and RBS must not drop without a release. Other behaviour only shows up in the bench's scenarios. These include the acceptance filter and the overrun drop of a third frame. They also include DLC clamping in the receive window, the effect of an abort before and after the engine takes the frame, and a wake-up event arriving in the same cycle as an interrupt read.

// File: rtl/can_hri_pkg.sv
package can_hri_pkg;
  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_CMD  = 1;
  localparam int A_STAT = 2;
  localparam int A_IRQ  = 3;
  localparam int A_CFG0 = 4;   // code, mask, timing0, timing1, output, divider
  localparam int A_BT0  = 6;
  localparam int A_TXB  = 10;
  localparam int NCFG   = 6;

  // control bits
  localparam int NCTRL    = 5;
  localparam int CTRL_RST = 0;
  localparam int CTRL_RIE = 1;
  localparam int CTRL_TIE = 2;
  localparam int CTRL_EIE = 3;
  localparam int CTRL_OIE = 4;
  localparam logic [NCTRL-1:0] CTRL_RST_VAL = 5'b00001;

  // command bits
  localparam int CMD_TX    = 0;
  localparam int CMD_ABORT = 1;
  localparam int CMD_REL   = 2;

  // interrupt bits
  localparam int NIRQ    = 5;
  localparam int IRQ_RI  = 0;
  localparam int IRQ_TI  = 1;
  localparam int IRQ_EI  = 2;
  localparam int IRQ_DOI = 3;
  localparam int IRQ_WUI = 4;

  function automatic logic [3:0] dlc_clamp(input logic [3:0] dlc, input int nbytes);
    return (int'(dlc) > nbytes) ? 4'(nbytes) : dlc;
  endfunction
endpackage

// File: rtl/can_hri_ctrl.sv
module can_hri_ctrl
  import can_hri_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic [7:0]           wdata,
  input  logic [NCFG-1:0]      wr_cfg,
  input  logic                 irq_rd,
  input  logic [NIRQ-1:0]      ev,
  input  logic                 err_evt,
  output logic [NCTRL-1:0]     ctrl_q,
  output logic [NCFG-1:0][7:0] cfg_q,
  output logic [NIRQ-1:0]      irq_q
);
  logic [NCTRL-1:0] ctrl_d;
  logic             ctrl_en;
  logic [NIRQ-1:0]  gate, irq_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wdata[NCTRL-1:0];
    if (err_evt) ctrl_d[CTRL_RST] = 1'b1;
  end
  assign ctrl_en = wr_ctrl | err_evt;

  always_comb begin
    gate          = '0;
    gate[IRQ_RI]  = ctrl_q[CTRL_RIE];
    gate[IRQ_TI]  = ctrl_q[CTRL_TIE];
    gate[IRQ_EI]  = ctrl_q[CTRL_EIE];
    gate[IRQ_DOI] = ctrl_q[CTRL_OIE];
    gate[IRQ_WUI] = 1'b1;
    irq_d = (irq_rd ? '0 : irq_q) | (ev & gate);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST_VAL;
      irq_q  <= '0;
      cfg_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      irq_q <= irq_d;
      for (int i = 0; i < NCFG; i++)
        if (wr_cfg[i] && ctrl_q[CTRL_RST]) cfg_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/can_hri_txbuf.sv
module can_hri_txbuf #(
  parameter int NB = 10,
  parameter int IW = $clog2(NB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               buf_we,
  input  logic [IW-1:0]      buf_idx,
  input  logic [7:0]         wdata,
  input  logic               cmd_tx,
  input  logic               cmd_abort,
  input  logic               reset_mode,
  input  logic               tx_start,
  input  logic               tx_done,
  output logic [NB-1:0][7:0] buf_q,
  output logic               tbs,
  output logic               tcs,
  output logic               tx_req,
  output logic               ti_evt
);
  logic tbs_q, tcs_q, pend_q, busy_q;
  logic tbs_d, tcs_d, pend_d, busy_d;

  always_comb begin
    tbs_d  = tbs_q;
    tcs_d  = tcs_q;
    pend_d = pend_q;
    busy_d = busy_q;
    ti_evt = 1'b0;
    if (tx_done && busy_q) begin
      pend_d = 1'b0; busy_d = 1'b0; tbs_d = 1'b1; tcs_d = 1'b1; ti_evt = 1'b1;
    end else if (tx_start && pend_q && !busy_q) begin
      busy_d = 1'b1;
    end else if (cmd_abort && pend_q && !busy_q) begin
      pend_d = 1'b0; tbs_d = 1'b1;
    end else if (cmd_tx && tbs_q && !reset_mode) begin
      pend_d = 1'b1; tbs_d = 1'b0; tcs_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbs_q  <= 1'b1;
      tcs_q  <= 1'b1;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      tbs_q  <= tbs_d;
      tcs_q  <= tcs_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
      if (buf_we && tbs_q) buf_q[buf_idx] <= wdata;
    end
  end

  assign tbs    = tbs_q;
  assign tcs    = tcs_q;
  assign tx_req = pend_q & ~busy_q;
endmodule

// File: rtl/can_hri_rxfifo.sv
module can_hri_rxfifo #(
  parameter int NB    = 10,
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [NB-1:0][7:0] frame,
  input  logic [7:0]         acode,
  input  logic [7:0]         amask,
  input  logic               enable,
  input  logic               rel_req,
  output logic [NB-1:0][7:0] head,
  output logic               rbs,
  output logic               ri_evt,
  output logic               doi_evt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NB-1:0][7:0] mem_q [DEPTH];
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [PW-1:0]      rp_q, wp_q;
  logic               match, take, pop, room, push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign match   = ((frame[0] ^ acode) & ~amask) == 8'h00;
  assign take    = rx_valid & enable & match;
  assign pop     = rel_req & (cnt_q != '0);
  assign room    = (cnt_q < CW'(DEPTH)) | pop;
  assign push    = take & room;
  assign ri_evt  = push;
  assign doi_evt = take & ~room;
  assign cnt_d   = cnt_q + CW'(push) - CW'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rp_q  <= '0;
      wp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push | pop) cnt_q <= cnt_d;
      if (pop)  rp_q <= nxt(rp_q);
      if (push) begin
        wp_q        <= nxt(wp_q);
        mem_q[wp_q] <= frame;
      end
    end
  end

  assign head = mem_q[rp_q];
  assign rbs  = cnt_q != '0;
endmodule

// File: rtl/can_hri_top.sv
module can_hri_top
  import can_hri_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_BYTES = 8,
  parameter int RX_DEPTH   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic                    wr,
  input  logic                    rd,
  output logic [7:0]              rdata,
  output logic                    irq_n,
  output logic                    reset_mode,
  output logic [7:0]              bt0,
  output logic [7:0]              bt1,
  output logic [7:0]              ocr,
  output logic [7:0]              cdr,
  output logic                    tx_req,
  input  logic                    tx_start,
  input  logic                    tx_done,
  output logic [10:0]             tx_id,
  output logic                    tx_rtr,
  output logic [3:0]              tx_dlc,
  output logic [8*DATA_BYTES-1:0] tx_data,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_id_hi,
  input  logic [7:0]              rx_id_lo,
  input  logic [8*DATA_BYTES-1:0] rx_data,
  input  logic                    err_evt,
  input  logic                    wake_evt
);
  localparam int NB    = DATA_BYTES + 2;
  localparam int IW    = $clog2(NB);
  localparam int CIW   = $clog2(NCFG);
  localparam int A_RXB = A_TXB + NB;

  logic [31:0]          a_w;
  logic                 wr_ctrl, cmd_wr, cmd_tx, cmd_abort, cmd_rel, irq_rd;
  logic [NCFG-1:0]      wr_cfg;
  logic                 tx_hit, rx_hit;
  logic [IW-1:0]        tx_idx, rx_idx;
  logic [CIW-1:0]       cfg_idx;
  logic [NCTRL-1:0]     ctrl_q;
  logic [NCFG-1:0][7:0] cfg_q;
  logic [NIRQ-1:0]      irq_q, ev;
  logic [NB-1:0][7:0]   tx_buf, rx_frame, head;
  logic                 tbs, tcs, rbs, ti_evt, ri_evt, doi_evt;
  logic [3:0]           rx_dlc;

  // address decode
  assign a_w       = 32'(addr);
  assign wr_ctrl   = wr & (a_w == A_CTRL);
  assign cmd_wr    = wr & (a_w == A_CMD);
  assign cmd_tx    = cmd_wr & wdata[CMD_TX];
  assign cmd_abort = cmd_wr & wdata[CMD_ABORT];
  assign cmd_rel   = cmd_wr & wdata[CMD_REL];
  assign irq_rd    = rd & (a_w == A_IRQ);
  assign tx_hit    = (a_w >= A_TXB) && (a_w < A_RXB);
  assign rx_hit    = (a_w >= A_RXB) && (a_w < A_RXB + NB);
  assign tx_idx    = IW'(a_w - 32'(A_TXB));
  assign rx_idx    = IW'(a_w - 32'(A_RXB));
  assign cfg_idx   = CIW'(a_w - 32'(A_CFG0));

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg_we
    assign wr_cfg[i] = wr & (a_w == A_CFG0 + i);
  end

  // event vector
  always_comb begin
    ev          = '0;
    ev[IRQ_RI]  = ri_evt;
    ev[IRQ_TI]  = ti_evt;
    ev[IRQ_EI]  = err_evt;
    ev[IRQ_DOI] = doi_evt;
    ev[IRQ_WUI] = wake_evt;
  end

  can_hri_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata), .wr_cfg(wr_cfg),
    .irq_rd(irq_rd), .ev(ev), .err_evt(err_evt),
    .ctrl_q(ctrl_q), .cfg_q(cfg_q), .irq_q(irq_q)
  );

  can_hri_txbuf #(.NB(NB), .IW(IW)) u_tx (
    .clk(clk), .rst_n(rst_n), .buf_we(wr & tx_hit), .buf_idx(tx_idx), .wdata(wdata),
    .cmd_tx(cmd_tx), .cmd_abort(cmd_abort), .reset_mode(reset_mode),
    .tx_start(tx_start), .tx_done(tx_done),
    .buf_q(tx_buf), .tbs(tbs), .tcs(tcs), .tx_req(tx_req), .ti_evt(ti_evt)
  );

  assign rx_frame[0] = rx_id_hi;
  assign rx_frame[1] = rx_id_lo;
  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_bytes
    assign rx_frame[2+i]    = rx_data[8*i +: 8];
    assign tx_data[8*i +: 8] = tx_buf[2+i];
  end

  can_hri_rxfifo #(.NB(NB), .DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .frame(rx_frame),
    .acode(cfg_q[0]), .amask(cfg_q[1]), .enable(~reset_mode), .rel_req(cmd_rel),
    .head(head), .rbs(rbs), .ri_evt(ri_evt), .doi_evt(doi_evt)
  );

  assign rx_dlc = dlc_clamp(head[1][3:0], DATA_BYTES);

  // read mux
  always_comb begin
    rdata = 8'h00;
    if (a_w == A_CTRL)
      rdata = 8'(ctrl_q);
    else if (a_w == A_STAT)
      rdata = {5'b0, tcs, tbs, rbs};
    else if (a_w == A_IRQ)
      rdata = 8'(irq_q);
    else if ((a_w >= A_CFG0) && (a_w < A_CFG0 + NCFG))
      rdata = cfg_q[cfg_idx];
    else if (tx_hit)
      rdata = tx_buf[tx_idx];
    else if (rx_hit && (32'(rx_idx) < 32'(rx_dlc) + 32'd2))
      rdata = head[rx_idx];
  end

  assign reset_mode = ctrl_q[CTRL_RST];
  assign irq_n      = ~|irq_q;
  assign bt0        = cfg_q[2];
  assign bt1        = cfg_q[3];
  assign ocr        = cfg_q[4];
  assign cdr        = cfg_q[5];
  assign tx_id      = {tx_buf[0], tx_buf[1][7:5]};
  assign tx_rtr     = tx_buf[1][4];
  assign tx_dlc     = tx_buf[1][3:0];
endmodule

// File: rtl/can_hri_chk.sv
module can_hri_chk
  import can_hri_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic              rd,
  input logic [7:0]        rdata,
  input logic              reset_mode,
  input logic [7:0]        bt0,
  input logic              tx_req,
  input logic              tx_done,
  input logic              tbs,
  input logic              tcs,
  input logic              err_evt,
  input logic              rx_valid,
  input logic              wake_evt,
  input logic              irq_n,
  input logic              rbs,
  input logic              cmd_rel
);
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_mode && wr && addr == ADDR_W'(A_BT0)) |=> $stable(bt0)); // R2

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_W'(A_CMD)) |-> (rdata == 8'h00)); // R4

  AST_TXREQ_LOCKS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> !tbs); // R5

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tbs && !tx_req) |=> (tbs && tcs)); // R6

  AST_RBS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rbs && !cmd_rel) |=> rbs); // R10

  AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_W'(A_IRQ) && !rx_valid && !tx_done && !err_evt && !wake_evt)
      |=> irq_n); // R13

  AST_ERR_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> reset_mode); // R14
endmodule

bind can_hri_top can_hri_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .rdata(rdata),
  .reset_mode(reset_mode), .bt0(bt0), .tx_req(tx_req), .tx_done(tx_done),
  .tbs(tbs), .tcs(tcs), .err_evt(err_evt), .rx_valid(rx_valid),
  .wake_evt(wake_evt), .irq_n(irq_n), .rbs(rbs), .cmd_rel(cmd_rel)
);

// File: tb/can_hri_top_tb.sv
`timescale 1ns/1ps
module can_hri_top_tb;
  localparam int DB = 8;
  localparam logic [4:0] A_CTRL = 5'd0, A_CMD = 5'd1, A_STAT = 5'd2, A_IRQ = 5'd3;
  localparam logic [4:0] A_ACODE = 5'd4, A_AMASK = 5'd5, A_BT0 = 5'd6;
  localparam logic [4:0] A_TXB = 5'd10, A_RXB = 5'd20;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic wr, rd, irq_n, reset_mode, tx_req, tx_start, tx_done, tx_rtr;
  logic [7:0] bt0, bt1, ocr, cdr, rx_id_hi, rx_id_lo;
  logic [10:0] tx_id;
  logic [3:0] tx_dlc;
  logic [8*DB-1:0] tx_data, rx_data;
  logic rx_valid, err_evt, wake_evt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_hri_top u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .irq_n(irq_n), .reset_mode(reset_mode), .bt0(bt0), .bt1(bt1),
    .ocr(ocr), .cdr(cdr), .tx_req(tx_req), .tx_start(tx_start), .tx_done(tx_done),
    .tx_id(tx_id), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_id_hi(rx_id_hi), .rx_id_lo(rx_id_lo), .rx_data(rx_data),
    .err_evt(err_evt), .wake_evt(wake_evt)
  );

  typedef struct packed {
    logic       w;
    logic [4:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_CTRL,   8'h00, 8'h01, 4'd1},  // R1 reset control
    '{1'b0, A_STAT,   8'h00, 8'h06, 4'd1},  // R1 reset status
    '{1'b0, A_IRQ,    8'h00, 8'h00, 4'd1},  // R1 no flags
    '{1'b0, A_BT0,    8'h00, 8'h00, 4'd1},  // R1 config cleared
    '{1'b1, A_BT0,    8'h5A, 8'h00, 4'd2},  // R2 write in reset mode
    '{1'b0, A_BT0,    8'h00, 8'h5A, 4'd2},
    '{1'b1, A_ACODE,  8'hA5, 8'h00, 4'd9},  // R9 filter setup
    '{1'b1, A_AMASK,  8'h0F, 8'h00, 4'd9},
    '{1'b1, A_CTRL,   8'h1E, 8'h00, 4'd3},  // R3 enables on, leave reset
    '{1'b0, A_CTRL,   8'h00, 8'h1E, 4'd3},
    '{1'b1, A_BT0,    8'h33, 8'h00, 4'd2},  // R2 ignored in operation
    '{1'b0, A_BT0,    8'h00, 8'h5A, 4'd2},
    '{1'b1, A_AMASK,  8'hFF, 8'h00, 4'd2},
    '{1'b0, A_AMASK,  8'h00, 8'h0F, 4'd2},
    '{1'b1, A_CMD,    8'h00, 8'h00, 4'd4},  // R4 command reads zero
    '{1'b0, A_CMD,    8'h00, 8'h00, 4'd4},
    '{1'b1, A_TXB,    8'h91, 8'h00, 4'd8},  // R8 transmit frame
    '{1'b1, 5'd11,    8'h68, 8'h00, 4'd8},
    '{1'b1, 5'd12,    8'h11, 8'h00, 4'd8},
    '{1'b1, 5'd19,    8'h99, 8'h00, 4'd8},
    '{1'b0, A_TXB,    8'h00, 8'h91, 4'd8},
    '{1'b0, 5'd19,    8'h00, 8'h99, 4'd8}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [4:0] a, input logic [7:0] e,
                        input string what);
    logic [7:0] v;
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
    chk(req, 32'(v), 32'(e), what);
  endtask

  function automatic logic [8*DB-1:0] pat(input logic [7:0] base);
    logic [8*DB-1:0] r;
    for (int i = 0; i < DB; i++) r[8*i +: 8] = base + 8'(i);
    return r;
  endfunction

  task automatic push_rx(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] base);
    @(negedge clk);
    rx_id_hi = hi; rx_id_lo = lo; rx_data = pat(base); rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tx_start = 1'b1;
      1: tx_done  = 1'b1;
      2: err_evt  = 1'b1;
      default: wake_evt = 1'b1;
    endcase
    @(negedge clk);
    tx_start = 1'b0; tx_done = 1'b0; err_evt = 1'b0; wake_evt = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
    tx_start = 1'b0; tx_done = 1'b0; rx_valid = 1'b0; rx_id_hi = '0; rx_id_lo = '0;
    rx_data = '0; err_evt = 1'b0; wake_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the pins
    chk(1, 32'(irq_n), 32'd1, "irq_n after reset");
    chk(1, 32'(tx_req), 32'd0, "tx_req after reset");
    chk(1, 32'(reset_mode), 32'd1, "reset_mode after reset");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].w) do_wr(VEC[k].a, VEC[k].d);
      else rd_chk(int'(VEC[k].r), VEC[k].a, VEC[k].e, $sformatf("vector %0d", k));
    end

    // R8 identifier layout toward the engine
    chk(8, 32'(tx_id), 32'h48B, "tx_id");
    chk(8, 32'(tx_rtr), 32'd0, "tx_rtr");
    chk(8, 32'(tx_dlc), 32'd8, "tx_dlc");
    chk(8, 32'(tx_data[7:0]), 32'h11, "tx_data byte0");
    chk(8, 32'(tx_data[63:56]), 32'h99, "tx_data byte7");

    // R5 transmit request locks the buffer
    do_wr(A_CMD, 8'h01);
    chk(5, 32'(tx_req), 32'd1, "tx_req after request");
    rd_chk(5, A_STAT, 8'h00, "status after request");
    rd_chk(4, A_CMD, 8'h00, "command reads zero after request");
    do_wr(A_TXB, 8'hFF);
    rd_chk(5, A_TXB, 8'h91, "locked buffer write ignored");

    // R7 abort before start
    do_wr(A_CMD, 8'h02);
    chk(7, 32'(tx_req), 32'd0, "tx_req after abort");
    rd_chk(7, A_STAT, 8'h02, "status after abort");
    rd_chk(7, A_IRQ, 8'h00, "no transmit flag on abort");

    // R7 abort after start has no effect; R6 done completes
    do_wr(A_CMD, 8'h01);
    pulse(0);
    chk(7, 32'(tx_req), 32'd0, "tx_req after start");
    do_wr(A_CMD, 8'h02);
    rd_chk(7, A_STAT, 8'h00, "late abort ignored");
    pulse(1);
    rd_chk(6, A_STAT, 8'h06, "status after done");
    chk(12, 32'(irq_n), 32'd0, "irq_n with transmit flag");
    rd_chk(6, A_IRQ, 8'h02, "transmit flag");
    rd_chk(13, A_IRQ, 8'h00, "flags cleared by read");
    chk(13, 32'(irq_n), 32'd1, "irq_n after clear");

    // R9 R10 R11 receive path
    push_rx(8'hA7, 8'h43, 8'h01);              // accepted, dlc 3
    rd_chk(10, A_STAT, 8'h07, "rbs after first frame");
    rd_chk(11, A_RXB, 8'hA7, "rx id hi");
    rd_chk(11, 5'd21, 8'h43, "rx id lo");
    rd_chk(11, 5'd22, 8'h01, "rx data0");
    rd_chk(11, 5'd24, 8'h03, "rx data2");
    rd_chk(11, 5'd25, 8'h00, "rx data3 beyond dlc");
    rd_chk(12, A_IRQ, 8'h01, "receive flag");
    push_rx(8'h55, 8'h01, 8'h40);              // rejected by filter
    rd_chk(9, A_IRQ, 8'h00, "rejected frame raises nothing");
    push_rx(8'hA0, 8'h2F, 8'h10);              // accepted, dlc 15
    push_rx(8'hAF, 8'h01, 8'h60);              // queue full, dropped
    rd_chk(10, A_IRQ, 8'h09, "receive plus overrun flags");
    do_wr(A_CMD, 8'h04);
    rd_chk(9, A_RXB, 8'hA0, "second accepted frame at head");
    rd_chk(11, 5'd29, 8'h17, "dlc above 8 reads all bytes");
    rd_chk(10, A_STAT, 8'h07, "rbs while frame pending");
    do_wr(A_CMD, 8'h04);
    rd_chk(10, A_STAT, 8'h06, "queue empty, third frame dropped");

    // R12 enable gating and wake-up
    do_wr(A_CTRL, 8'h1C);
    push_rx(8'hA1, 8'h00, 8'h00);
    rd_chk(12, A_IRQ, 8'h00, "receive flag gated off");
    rd_chk(12, A_STAT, 8'h07, "frame still queued");
    pulse(3);
    rd_chk(12, A_IRQ, 8'h10, "wake flag always enabled");
    do_wr(A_CMD, 8'h04);

    // R13 event in the same cycle as the clearing read
    do_wr(A_CTRL, 8'h1E);
    push_rx(8'hA2, 8'h00, 8'h00);
    @(negedge clk);
    addr = A_IRQ; rd = 1'b1; wake_evt = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0; wake_evt = 1'b0;
    chk(13, 32'(v), 32'h01, "read value before clear");
    rd_chk(13, A_IRQ, 8'h10, "same-cycle event kept");
    do_wr(A_CMD, 8'h04);

    // R14 error forces reset mode
    pulse(2);
    rd_chk(14, A_CTRL, 8'h1F, "control after error");
    rd_chk(14, A_IRQ, 8'h04, "error flag");
    do_wr(A_BT0, 8'h77);
    rd_chk(2, A_BT0, 8'h77, "config writable after error");
    do_wr(A_CMD, 8'h01);
    chk(5, 32'(tx_req), 32'd0, "request ignored in reset mode");
    rd_chk(5, A_STAT, 8'h06, "status unchanged in reset mode");
    do_wr(A_CTRL, 8'h00);
    rd_chk(3, A_CTRL, 8'h00, "control cleared");

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(1, A_CTRL, 8'h01, "control after second reset");
    rd_chk(1, A_BT0, 8'h00, "timing after second reset");
    chk(1, 32'(bt0), 32'd0, "bt0 pin after second reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule